// File: doc/BRIEF.md
# Bridge Converter Readout Controller

This block sits on the host side of a two-wire link to a delta-sigma bridge converter. The converter shares one output line between a "result ready" indication and the serial data. When that line goes low, the controller drives a serial clock. The clock's high and low phases never fall below a minimum width, which is set by parameters from the system clock frequency. The controller shifts in a 24-bit two's-complement result, most significant bit first. It then sends one extra clock pulse so that the converter drives the line high again, ready for the next poll.

The finished word is presented on a registered bus with a one-cycle valid strobe. After a channel change, the host raises a discard request. The controller then keeps the unsettled readings that follow from reaching the output, and releases only the first settled one. In single-shot mode, the controller holds the serial clock high after a readback so that the converter drops into standby. When a shot request arrives, the clock goes low, which wakes the converter for one fresh conversion.

Top module: `bridge_adc_reader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, sclk_o is low, valid_o is low and word_o is zero.
- R2: No rising edge of sclk_o occurs while the data/ready line stays high. A readback begins only after the synchronised line is seen low.
- R3: Every high phase and every low phase of sclk_o lasts at least HALF_CYC system clocks. With the defaults this is 20 cycles of a 200 MHz clock, 100 ns.
- R4: A readback issues exactly 25 rising edges on sclk_o. The 24 bits that follow rising edges 1 to 24 form word_o, first bit in word_o[23], so the word is two's complement with bit 23 as the sign.
- R5: valid_o is high for exactly one cycle per accepted readback, and word_o changes only in that cycle.
- R6: After the 25th rising edge, no new readback starts until the line has been seen high again, even if it is held low.
- R7: A discard request suppresses the next four completed readbacks: valid_o stays low and word_o holds. The fifth is delivered. A new request reloads the count, and a request in the same cycle as a completion suppresses that completion.
- R8: With oneshot_i high, sclk_o stays high after the 25th rising edge until shot_req_i is pulsed. It then goes low, and the next result is read normally.
- R9: With oneshot_i low, no high phase of sclk_o exceeds HALF_CYC system clocks. Clearing oneshot_i during standby releases sclk_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sdo_i | input | 1 | Shared ready/data line from the converter (low = ready, then serial data) |
| oneshot_i | input | 1 | 1 = single-shot mode with standby between readings, 0 = continuous |
| shot_req_i | input | 1 | One-cycle request to wake the converter from standby |
| discard_i | input | 1 | One-cycle request to drop the next four readings |
| sclk_o | output | 1 | Serial clock to the converter |
| word_o | output | 24 | Last accepted result, two's complement |
| valid_o | output | 1 | One-cycle strobe marking a new word_o |

## Verification
The hardest case to reach is the shared line held low right after the 25th pulse. A converter that follows the protocol never does this, so a correct controller is never shown whether it would start a second, bogus readback. The bench's converter model has an override that pins the line low one nanosecond after the 25th rising edge. It then watches for more clock edges while the line is pinned and again after it is released. Discard reloading is exercised in a similar way: a second discard request is raised partway through a suppressed run.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    RD_IDLE,
    RD_HIGH,
    RD_LOW,
    RD_DRAIN,
    RD_STBY
  } rd_state_e;
endpackage

// File: rtl/rd_sync.sv
module rd_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= {STAGES{RST_VAL}};
    else     ff <= {ff[STAGES-2:0], d_i};
  end

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/rd_seq.sv
module rd_seq
  import adc_rd_pkg::*;
#(
  parameter int HALF_CYC = 20,
  parameter int NBITS    = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic oneshot_i,
  input  logic shot_req_i,
  output logic sclk_o,
  output logic smp_o,
  output logic done_o
);
  localparam int NPULSE = NBITS + 1;
  localparam int PW     = $clog2(NPULSE + 1);
  localparam int TW     = $clog2(HALF_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] T_SMP  = TW'(HALF_CYC - 2);
  localparam logic [PW-1:0] P_LAST = PW'(NPULSE);
  localparam logic [PW-1:0] P_DATA = PW'(NBITS);

  rd_state_e       st;
  logic [TW-1:0]   tcnt;
  logic [PW-1:0]   pcnt;

  // bit taken one system clock before the next rising edge
  assign smp_o = (st == RD_LOW) && (tcnt == T_SMP) && (pcnt <= P_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= RD_IDLE;
      sclk_o <= 1'b0;
      tcnt   <= '0;
      pcnt   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        RD_IDLE: begin
          if (tcnt != T_LAST) tcnt <= tcnt + 1'b1;
          if (!line_i && tcnt == T_LAST) begin
            st     <= RD_HIGH;
            sclk_o <= 1'b1;
            tcnt   <= '0;
            pcnt   <= PW'(1);
          end
        end
        RD_HIGH: begin
          if (tcnt == T_LAST) begin
            if (pcnt == P_LAST && oneshot_i) begin
              st     <= RD_STBY;
              done_o <= 1'b1;
            end else begin
              st     <= RD_LOW;
              sclk_o <= 1'b0;
              tcnt   <= '0;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RD_LOW: begin
          if (tcnt == T_LAST) begin
            if (pcnt == P_LAST) begin
              st     <= RD_DRAIN;
              done_o <= 1'b1;
            end else begin
              st     <= RD_HIGH;
              sclk_o <= 1'b1;
              tcnt   <= '0;
              pcnt   <= pcnt + 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RD_DRAIN: begin
          if (tcnt != T_LAST) tcnt <= tcnt + 1'b1;
          if (line_i) st <= RD_IDLE;
        end
        RD_STBY: begin
          if (!oneshot_i || shot_req_i) begin
            st     <= RD_DRAIN;
            sclk_o <= 1'b0;
            tcnt   <= '0;
          end
        end
        default: st <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rd_shift.sv
module rd_shift #(
  parameter int NBITS = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_i,
  input  logic             bit_i,
  output logic [NBITS-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst)        data_o <= '0;
    else if (smp_i) data_o <= {data_o[NBITS-2:0], bit_i};
  end
endmodule

// File: rtl/rd_settle.sv
module rd_settle #(
  parameter int NBITS = 24,
  parameter int SKIP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             discard_i,
  input  logic             done_i,
  input  logic [NBITS-1:0] data_i,
  output logic [NBITS-1:0] word_o,
  output logic             valid_o
);
  localparam int CW = $clog2(SKIP + 1);
  localparam logic [CW-1:0] C_LOAD = CW'(SKIP);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (discard_i) begin
        left <= C_LOAD;
      end else if (done_i) begin
        if (left != '0) begin
          left <= left - 1'b1;
        end else begin
          word_o  <= data_i;
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bridge_adc_reader.sv
module bridge_adc_reader #(
  parameter int CLK_MHZ     = 200,
  parameter int SCLK_MIN_NS = 100,
  parameter int NBITS       = 24,
  parameter int SKIP_READS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sdo_i,
  input  logic             oneshot_i,
  input  logic             shot_req_i,
  input  logic             discard_i,
  output logic             sclk_o,
  output logic [NBITS-1:0] word_o,
  output logic             valid_o
);
  localparam int HALF_RAW = (SCLK_MIN_NS * CLK_MHZ + 999) / 1000;
  localparam int HALF_CYC = (HALF_RAW < 2) ? 2 : HALF_RAW;

  logic             line_s;
  logic             smp;
  logic             done;
  logic [NBITS-1:0] shreg;

  rd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rst(rst), .d_i(sdo_i), .q_o(line_s)
  );

  rd_seq #(.HALF_CYC(HALF_CYC), .NBITS(NBITS)) i_seq (
    .clk(clk), .rst(rst), .line_i(line_s), .oneshot_i(oneshot_i),
    .shot_req_i(shot_req_i), .sclk_o(sclk_o), .smp_o(smp), .done_o(done)
  );

  rd_shift #(.NBITS(NBITS)) i_shift (
    .clk(clk), .rst(rst), .smp_i(smp), .bit_i(line_s), .data_o(shreg)
  );

  rd_settle #(.NBITS(NBITS), .SKIP(SKIP_READS)) i_settle (
    .clk(clk), .rst(rst), .discard_i(discard_i), .done_i(done),
    .data_i(shreg), .word_o(word_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/bridge_adc_reader_chk.sv
module bridge_adc_reader_chk #(
  parameter int HALF_CYC = 20,
  parameter int NBITS    = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             oneshot_i,
  input logic             sclk_o,
  input logic [NBITS-1:0] word_o,
  input logic             valid_o
);
  logic [15:0] hi_len;
  logic [15:0] lo_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_len <= '0;
      lo_len <= '0;
    end else if (sclk_o) begin
      lo_len <= '0;
      if (hi_len != 16'hFFFF) hi_len <= hi_len + 1'b1;
    end else begin
      hi_len <= '0;
      if (lo_len != 16'hFFFF) lo_len <= lo_len + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sclk_o && !valid_o && word_o == '0)); // R1
  AST_SCLK_HI_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> (hi_len >= 16'(HALF_CYC))); // R3
  AST_SCLK_LO_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> (lo_len >= 16'(HALF_CYC))); // R3
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R5
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(word_o)); // R5
  AST_CONT_HI_MAX: assert property (@(posedge clk) disable iff (rst)
    (!oneshot_i && $past(!oneshot_i) && sclk_o) |-> (hi_len < 16'(HALF_CYC))); // R9
endmodule

bind bridge_adc_reader bridge_adc_reader_chk #(.HALF_CYC(HALF_CYC), .NBITS(NBITS)) i_chk (
  .clk(clk), .rst(rst), .oneshot_i(oneshot_i), .sclk_o(sclk_o),
  .word_o(word_o), .valid_o(valid_o)
);

// File: tb/test_bridge_adc_reader.sv
`timescale 1ns/1ps
module test_bridge_adc_reader;
  localparam int HALF = 20; // 100 ns at 5 ns per cycle

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, oneshot = 1'b0, shot_req = 1'b0, discard = 1'b0;
  logic line_r = 1'b1, stuck_low = 1'b0;
  wire  sdo = stuck_low ? 1'b0 : line_r;
  logic sclk, valid;
  logic [23:0] word;

  bridge_adc_reader i_bridge_adc_reader (
    .clk(clk), .rst(rst), .sdo_i(sdo), .oneshot_i(oneshot), .shot_req_i(shot_req),
    .discard_i(discard), .sclk_o(sclk), .word_o(word), .valid_o(valid)
  );

  int nchk = 0, nfail = 0;
  int rises = 0, vcount = 0;
  logic [23:0] tx = '0;

  // converter model: new bit 20 ns after each rising edge, high after edge 25
  always @(posedge sclk) begin
    rises = rises + 1;
    if (rises <= 24) line_r <= #20 tx[24 - rises];
    else             line_r <= #20 1'b1;
  end

  // pulse width monitor
  int min_hi = 100000, min_lo = 100000, max_hi = 0, run = 0;
  logic prev_s = 1'b0;
  always @(negedge clk) begin
    if (valid) vcount = vcount + 1;
    if (sclk == prev_s) run = run + 1;
    else begin
      if (prev_s) begin
        if (run < min_hi) min_hi = run;
        if (run > max_hi) max_hi = run;
      end else if (run < min_lo) min_lo = run;
      run = 1;
    end
    prev_s = sclk;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic present(input logic [23:0] w);
    tx = w; rises = 0; line_r = 1'b0;
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 5000 && !got; i++) begin
      @(negedge clk);
      if (valid) got = 1'b1;
    end
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk(sclk == 1'b0 && valid == 1'b0 && word == '0, "R1 reset outputs", {sclk, valid, word}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0 && valid == 1'b0 && word == '0, "R1 first cycle", {sclk, valid, word}, 0);
    repeat (100) @(negedge clk);
    chk(rises == 0, "R2 no clock while line high", rises, 0);
  endtask

  task automatic t_frame(input logic [23:0] w);
    bit got;
    present(w);
    wait_valid(got);
    chk(got, "R5 valid strobe", got, 1);
    chk(word == w, "R4 word value", word, w);
    chk(rises == 25, "R4 pulse count", rises, 25);
    @(negedge clk);
    chk(valid == 1'b0, "R5 single-cycle valid", valid, 0);
    repeat (60) @(negedge clk);
  endtask

  task automatic t_restart();
    bit got;
    present(24'h13579B);
    wait (rises == 25);
    #1 stuck_low = 1'b1;
    wait_valid(got);
    chk(got && word == 24'h13579B, "R6 word before stuck line", word, 24'h13579B);
    repeat (300) @(negedge clk);
    chk(rises == 25, "R6 no restart while line low", rises, 25);
    chk(sclk == 1'b0, "R6 clock parked low", sclk, 0);
    stuck_low = 1'b0;
    repeat (100) @(negedge clk);
    chk(rises == 25, "R2 idle after release", rises, 25);
  endtask

  task automatic quiet_frame(input logic [23:0] w);
    present(w);
    wait (rises == 25);
    repeat (80) @(negedge clk);
  endtask

  task automatic t_discard();
    bit got;
    logic [23:0] keep;
    keep = word;
    vcount = 0;
    @(negedge clk); discard = 1'b1; @(negedge clk); discard = 1'b0;
    quiet_frame(24'h000001);
    quiet_frame(24'h000002);
    @(negedge clk); discard = 1'b1; @(negedge clk); discard = 1'b0; // reload
    for (int k = 0; k < 4; k++) quiet_frame(24'h100000 + 24'(k));
    chk(vcount == 0, "R7 suppressed readings", vcount, 0);
    chk(word == keep, "R7 word held", word, keep);
    present(24'hFFFFFF);
    wait_valid(got);
    chk(got && word == 24'hFFFFFF, "R7 fifth reading delivered", word, 24'hFFFFFF);
    repeat (60) @(negedge clk);
  endtask

  task automatic t_single();
    bit got;
    chk(max_hi <= HALF, "R9 continuous high phase", max_hi, HALF);
    oneshot = 1'b1;
    present(24'h2468AC);
    wait_valid(got);
    chk(got && word == 24'h2468AC, "R8 first shot word", word, 24'h2468AC);
    repeat (400) @(negedge clk);
    chk(sclk == 1'b1, "R8 clock held high for standby", sclk, 1);
    chk(rises == 25, "R8 no extra pulses in standby", rises, 25);
    shot_req = 1'b1; @(negedge clk); shot_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b0, "R8 wake drives clock low", sclk, 0);
    repeat (50) @(negedge clk);
    present(24'h800000);
    wait_valid(got);
    chk(got && word == 24'h800000, "R8 result after wake", word, 24'h800000);
    repeat (10) @(negedge clk);
    chk(sclk == 1'b1, "R8 standby again", sclk, 1);
    oneshot = 1'b0;
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0, "R9 leaving single-shot releases clock", sclk, 0);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_frame(24'hA5A5A5);
    t_frame(24'h7FFFFF);
    t_frame(24'h800000);
    t_frame(24'h000000);
    t_restart();
    t_frame(24'h5A0FF0);
    t_discard();
    t_single();
    t_frame(24'hC0FFEE);
    chk(min_hi >= HALF, "R3 minimum high phase", min_hi, HALF);
    chk(min_lo >= HALF, "R3 minimum low phase", min_lo, HALF);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule